// File: doc/BRIEF.md
# Receive Traffic Statistics Monitor

This block watches a received packet stream, one beat per clock, marked by valid, start and end flags, an empty-byte count on the closing beat and six per-packet error flags. It keeps a set of statistics that software reads over a register bus with a 16-bit address. The bus returns 32-bit data on the clock after the read strobe.

The statistics are counts of total, good and bad packets, a byte count split into a low word and a high word, and a sticky error register. The error register holds one bit per receive-error cause and a summary bit. A packet is classed as bad when its closing beat carries any error flag. Bytes are counted on every beat that belongs to a packet. Reading the low byte word freezes the high part, so a following read of the high word returns a value that matches it. A bus write to the error register clears it, whatever value is written. The counters stop at all-ones rather than wrapping.

Top module: `traffic_stat_mon`

## Requirements
- R1: After reset, every statistics register reads as zero.
- R2: Reads are decoded as follows: 0x3d00 total packets, 0x3d01 good packets, 0x3d02 bad packets, 0x3d03 low byte word, 0x3d04 high byte word, 0x3d07 error status. Every other address reads zero. Read data appears on `regRdata` one clock after `regRd` and holds until the next read.
- R3: On the closing beat (`rxEop`) of a packet, the total count increments. The good count increments if `rxErr` is zero on that beat, and the bad count increments otherwise. Error flags on earlier beats are ignored.
- R4: A beat with `rxSop` set opens a packet, and the packet stays open until its closing beat. A valid beat that arrives with no packet open and without `rxSop` is ignored: it adds no bytes and no packet count.
- R5: Each non-closing beat of a packet adds DATA_BYTES to the byte count. The closing beat adds DATA_BYTES minus `rxEmpty`.
- R6: In the error status word, `rxErr[5:0]` on a closing beat sets bits 9 down to 4 (overflow=5→9, length=4→8, oversize=3→7, undersize=2→6, crc=1→5, phy=0→4). Bit 3 is set whenever any of bits 9..4 is set. All these bits are sticky.
- R7: A bus write to 0x3d07 clears the error status. Errors that arrive on a closing beat in the same cycle as the write are still recorded. Writes to any other address have no effect.
- R8: A read of 0x3d03 returns the low LO_W bits of the byte count and captures the bits above them. A read of 0x3d04 returns that captured value, not the live count.
- R9: The packet counters stop at their all-ones value.
- R10: The byte counter stops at its all-ones value.
- R11: A packet of a single beat, with `rxSop` and `rxEop` both set, counts as a complete packet and adds DATA_BYTES minus `rxEmpty` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | Beat present on the stream |
| rxSop | input | 1 | First beat of a packet |
| rxEop | input | 1 | Closing beat of a packet |
| rxEmpty | input | EMPTY_W | Unused bytes on the closing beat |
| rxErr | input | 6 | Error causes: overflow, length, oversize, undersize, crc, phy (bit 5 down to 0) |
| regAddr | input | 16 | Register bus address |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe (data is not used) |
| regRdata | output | 32 | Registered read data |

## Verification
The bench targets several corner cases, and each has a visible failure mode:
- Error flags on beats before the closing one must not count. A design that sampled them would misclass good packets as bad.
- A clear write in the same cycle as an erroring closing beat must keep the new cause. A design that let the clear win would lose that cause.
- Stray beats outside any packet must be ignored. A design that counted them would inflate the byte count.
- A high-word read after the byte count has moved past a word boundary must return the value captured at the low-word read. A design that returned the live value would give an incoherent pair.
- The counters are driven past all-ones. A design that wrapped would read back small values.

// File: rtl/traffic_stat_pkg.sv
package traffic_stat_pkg;

  localparam logic [15:0] ADR_TOTAL = 16'h3d00;
  localparam logic [15:0] ADR_GOOD  = 16'h3d01;
  localparam logic [15:0] ADR_BAD   = 16'h3d02;
  localparam logic [15:0] ADR_BLO   = 16'h3d03;
  localparam logic [15:0] ADR_BHI   = 16'h3d04;
  localparam logic [15:0] ADR_ERR   = 16'h3d07;

  localparam int NUM_CAUSE = 6;
  localparam int CAUSE_LSB = 4;
  localparam int SUMMARY_BIT = 3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TOTAL, SEL_GOOD, SEL_BAD, SEL_BLO, SEL_BHI, SEL_ERR
  } rd_sel_e;

  typedef struct packed {
    logic                 incTotal;
    logic                 incGood;
    logic                 incBad;
    logic [NUM_CAUSE-1:0] errSet;
    logic                 clrErr;
    logic                 snapHi;
    logic                 rdEn;
    rd_sel_e              rdSel;
  } stat_strobe_t;

endpackage

// File: rtl/stat_sat_ctr.sv
module stat_sat_ctr #(
  parameter int W  = 32,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  value
);
  localparam int SW = W + 1;

  logic [W:0] sum;
  assign sum = {1'b0, value} + SW'(inc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (|inc) begin
      value <= sum[W] ? '1 : sum[W-1:0];
    end
  end
endmodule

// File: rtl/traffic_stat_ctrl.sv
module traffic_stat_ctrl
  import traffic_stat_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int EMPTY_W    = $clog2(DATA_BYTES),
  parameter int ADD_W      = $clog2(DATA_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxValid,
  input  logic                 rxSop,
  input  logic                 rxEop,
  input  logic [EMPTY_W-1:0]   rxEmpty,
  input  logic [NUM_CAUSE-1:0] rxErr,
  input  logic [15:0]          regAddr,
  input  logic                 regRd,
  input  logic                 regWr,
  output stat_strobe_t         stb,
  output logic [ADD_W-1:0]     byteAdd,
  output logic                 inPkt
);
  logic accept;
  logic lastBeat;
  logic anyErr;

  assign accept   = rxValid && (rxSop || inPkt);
  assign lastBeat = accept && rxEop;
  assign anyErr   = |rxErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt <= 1'b0;
    end else if (accept) begin
      inPkt <= !rxEop;
    end
  end

  always_comb begin
    if (!accept) begin
      byteAdd = '0;
    end else if (rxEop) begin
      byteAdd = ADD_W'(DATA_BYTES) - ADD_W'(rxEmpty);
    end else begin
      byteAdd = ADD_W'(DATA_BYTES);
    end
  end

  rd_sel_e sel;
  always_comb begin
    case (regAddr)
      ADR_TOTAL: sel = SEL_TOTAL;
      ADR_GOOD:  sel = SEL_GOOD;
      ADR_BAD:   sel = SEL_BAD;
      ADR_BLO:   sel = SEL_BLO;
      ADR_BHI:   sel = SEL_BHI;
      ADR_ERR:   sel = SEL_ERR;
      default:   sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.incTotal = lastBeat;
    stb.incGood  = lastBeat && !anyErr;
    stb.incBad   = lastBeat && anyErr;
    stb.errSet   = lastBeat ? rxErr : '0;
    stb.clrErr   = regWr && (sel == SEL_ERR);
    stb.snapHi   = regRd && (sel == SEL_BLO);
    stb.rdEn     = regRd;
    stb.rdSel    = sel;
  end
endmodule

// File: rtl/traffic_stat_dpath.sv
module traffic_stat_dpath
  import traffic_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 64,
  parameter int LO_W   = 32,
  parameter int ADD_W  = 4,
  parameter int REG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stat_strobe_t         stb,
  input  logic [ADD_W-1:0]     byteAdd,
  output logic [REG_W-1:0]     regRdata,
  output logic [CNT_W-1:0]     totCnt,
  output logic [CNT_W-1:0]     goodCnt,
  output logic [CNT_W-1:0]     badCnt,
  output logic [BYTE_W-1:0]    byteCnt,
  output logic [NUM_CAUSE-1:0] errCause,
  output logic                 errAny
);
  localparam int HI_W = BYTE_W - LO_W;

  logic [2:0][CNT_W-1:0] pktCnt;
  logic [2:0]            pktInc;

  assign pktInc = {stb.incBad, stb.incGood, stb.incTotal};

  for (genvar g = 0; g < 3; g++) begin : g_pkt
    stat_sat_ctr #(.W(CNT_W), .IW(1)) u_ctr (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (pktInc[g]),
      .value (pktCnt[g])
    );
  end

  assign totCnt  = pktCnt[0];
  assign goodCnt = pktCnt[1];
  assign badCnt  = pktCnt[2];

  stat_sat_ctr #(.W(BYTE_W), .IW(ADD_W)) u_bytes (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (byteAdd),
    .value (byteCnt)
  );

  logic [HI_W-1:0] hiSnap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCause <= '0;
      errAny   <= 1'b0;
      hiSnap   <= '0;
    end else begin
      if (stb.clrErr) begin
        errCause <= stb.errSet;
        errAny   <= |stb.errSet;
      end else begin
        errCause <= errCause | stb.errSet;
        errAny   <= errAny | (|stb.errSet);
      end
      if (stb.snapHi) begin
        hiSnap <= byteCnt[BYTE_W-1:LO_W];
      end
    end
  end

  logic [REG_W-1:0] errWord;
  always_comb begin
    errWord = '0;
    errWord[CAUSE_LSB +: NUM_CAUSE] = errCause;
    errWord[SUMMARY_BIT] = errAny;
  end

  logic [REG_W-1:0] rdNext;
  always_comb begin
    case (stb.rdSel)
      SEL_TOTAL: rdNext = REG_W'(totCnt);
      SEL_GOOD:  rdNext = REG_W'(goodCnt);
      SEL_BAD:   rdNext = REG_W'(badCnt);
      SEL_BLO:   rdNext = REG_W'(byteCnt[LO_W-1:0]);
      SEL_BHI:   rdNext = REG_W'(hiSnap);
      SEL_ERR:   rdNext = errWord;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (stb.rdEn) begin
      regRdata <= rdNext;
    end
  end
endmodule

// File: rtl/traffic_stat_mon.sv
module traffic_stat_mon
  import traffic_stat_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int CNT_W      = 32,
  parameter int BYTE_W     = 64,
  parameter int LO_W       = 32,
  parameter int EMPTY_W    = $clog2(DATA_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxValid,
  input  logic                 rxSop,
  input  logic                 rxEop,
  input  logic [EMPTY_W-1:0]   rxEmpty,
  input  logic [NUM_CAUSE-1:0] rxErr,
  input  logic [15:0]          regAddr,
  input  logic                 regRd,
  input  logic                 regWr,
  output logic [31:0]          regRdata
);
  localparam int ADD_W = $clog2(DATA_BYTES + 1);

  stat_strobe_t         stb;
  logic [ADD_W-1:0]     byteAdd;
  logic                 inPkt;
  logic [CNT_W-1:0]     totCnt;
  logic [CNT_W-1:0]     goodCnt;
  logic [CNT_W-1:0]     badCnt;
  logic [BYTE_W-1:0]    byteCnt;
  logic [NUM_CAUSE-1:0] errCause;
  logic                 errAny;

  traffic_stat_ctrl #(
    .DATA_BYTES (DATA_BYTES),
    .EMPTY_W    (EMPTY_W),
    .ADD_W      (ADD_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxSop   (rxSop),
    .rxEop   (rxEop),
    .rxEmpty (rxEmpty),
    .rxErr   (rxErr),
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .stb     (stb),
    .byteAdd (byteAdd),
    .inPkt   (inPkt)
  );

  traffic_stat_dpath #(
    .CNT_W  (CNT_W),
    .BYTE_W (BYTE_W),
    .LO_W   (LO_W),
    .ADD_W  (ADD_W),
    .REG_W  (32)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .byteAdd  (byteAdd),
    .regRdata (regRdata),
    .totCnt   (totCnt),
    .goodCnt  (goodCnt),
    .badCnt   (badCnt),
    .byteCnt  (byteCnt),
    .errCause (errCause),
    .errAny   (errAny)
  );
endmodule

// File: rtl/traffic_stat_chk.sv
module traffic_stat_chk #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              rxSop,
  input logic              rxEop,
  input logic [5:0]        rxErr,
  input logic [15:0]       regAddr,
  input logic              regWr,
  input logic              inPkt,
  input logic [CNT_W-1:0]  totCnt,
  input logic [CNT_W-1:0]  goodCnt,
  input logic [CNT_W-1:0]  badCnt,
  input logic [BYTE_W-1:0] byteCnt,
  input logic [5:0]        errCause,
  input logic              errAny
);
  // R6: the summary bit agrees with the cause bits
  p_summary_r6: assert property (@(posedge clk) disable iff (!rstN)
    errAny == (|errCause));

  // R3: a packet is never counted as both good and bad
  p_one_class_r3: assert property (@(posedge clk) disable iff (!rstN)
    !((goodCnt != $past(goodCnt)) && (badCnt != $past(badCnt))));

  // R4: a stray beat outside a packet adds no bytes
  p_stray_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxSop && !inPkt) |=> $stable(byteCnt));

  // R7: a clear with no erroring closing beat empties the causes
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 16'h3d07 && !(rxValid && rxEop && (|rxErr)))
      |=> (errCause == '0));

  // R9: the packet counters never move backwards and hold at all-ones
  p_total_mono_r9: assert property (@(posedge clk) disable iff (!rstN)
    totCnt >= $past(totCnt));
  p_good_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (&goodCnt) |=> (&goodCnt));

  // R10: the byte count never moves backwards
  p_bytes_mono_r10: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt >= $past(byteCnt));
endmodule

bind traffic_stat_mon traffic_stat_chk #(
  .CNT_W  (CNT_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxValid  (rxValid),
  .rxSop    (rxSop),
  .rxEop    (rxEop),
  .rxErr    (rxErr),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .inPkt    (inPkt),
  .totCnt   (totCnt),
  .goodCnt  (goodCnt),
  .badCnt   (badCnt),
  .byteCnt  (byteCnt),
  .errCause (errCause),
  .errAny   (errAny)
);

// File: tb/traffic_stat_mon_bench.sv
module traffic_stat_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DB     = 8;
  localparam int CNT_W  = 10;
  localparam int BYTE_W = 16;
  localparam int LO_W   = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int BMAX   = (1 << BYTE_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxSop = 1'b0, rxEop = 1'b0;
  logic [2:0]  rxEmpty = '0;
  logic [5:0]  rxErr = '0;
  logic [15:0] regAddr = '0;
  logic        regRd = 1'b0, regWr = 1'b0;
  logic [31:0] regRdata;

  traffic_stat_mon #(
    .DATA_BYTES (DB), .CNT_W (CNT_W), .BYTE_W (BYTE_W), .LO_W (LO_W)
  ) u_traffic_stat_mon (
    .clk (clk), .rstN (rstN), .rxValid (rxValid), .rxSop (rxSop),
    .rxEop (rxEop), .rxEmpty (rxEmpty), .rxErr (rxErr),
    .regAddr (regAddr), .regRd (regRd), .regWr (regWr),
    .regRdata (regRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";
  bit started = 0;
  bit stopRd = 0;

  // reference model
  int mTot = 0, mGood = 0, mBad = 0, mBytes = 0, mSnap = 0, mErr = 0;
  bit mIn = 0;
  logic [31:0] expRd = '0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      mTot = 0; mGood = 0; mBad = 0; mBytes = 0; mSnap = 0; mErr = 0;
      mIn = 0; expRd = '0;
    end else begin
      bit acc;
      if (regRd) begin
        case (regAddr)
          16'h3d00: expRd = mTot;
          16'h3d01: expRd = mGood;
          16'h3d02: expRd = mBad;
          16'h3d03: begin expRd = mBytes % 256; mSnap = mBytes / 256; end
          16'h3d04: expRd = mSnap;
          16'h3d07: expRd = (mErr << 4) | ((mErr != 0) ? 8 : 0);
          default:  expRd = 0;
        endcase
      end
      if (regWr && regAddr == 16'h3d07) mErr = 0;
      acc = rxValid && (rxSop || mIn);
      if (acc) begin
        mBytes = mBytes + (rxEop ? DB - rxEmpty : DB);
        if (mBytes > BMAX) mBytes = BMAX;
        if (rxEop) begin
          if (mTot < CMAX) mTot++;
          if (rxErr != 0) begin
            if (mBad < CMAX) mBad++;
            mErr = mErr | rxErr;
          end else if (mGood < CMAX) mGood++;
        end
        mIn = !rxEop;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      nChecks++;
      if (regRdata !== expRd) begin
        nFail++;
        $display("FAIL %s: regRdata=%h expected=%h", curReq, regRdata, expRd);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic rdChk(string req, logic [15:0] a, logic [31:0] exp);
    rd(a);
    chk(req, regRdata, exp);
  endtask

  task automatic wr(logic [15:0] a);
    @(negedge clk); regWr = 1'b1; regAddr = a;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic sendPkt(int n, int emp, logic [5:0] err, logic [5:0] midErr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSop = (i == 0); rxEop = (i == n - 1);
      rxEmpty = (i == n - 1) ? 3'(emp) : 3'($urandom);
      rxErr = (i == n - 1) ? err : midErr;
    end
    @(negedge clk); rxValid = 1'b0; rxSop = 1'b0; rxEop = 1'b0; rxErr = '0;
  endtask

  task automatic reader();
    logic [15:0] addrs [8] = '{16'h3d00, 16'h3d01, 16'h3d02, 16'h3d03,
                               16'h3d04, 16'h3d07, 16'h3d05, 16'h3d03};
    while (!stopRd) rd(addrs[$urandom % 8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int savedHi, savedLo, savedGood;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    rdChk("R1", 16'h3d00, 0); rdChk("R1", 16'h3d01, 0);
    rdChk("R1", 16'h3d02, 0); rdChk("R1", 16'h3d03, 0);
    rdChk("R1", 16'h3d04, 0); rdChk("R1", 16'h3d07, 0);

    // R2: unmapped addresses read zero
    curReq = "R2";
    rdChk("R2", 16'h3d05, 0); rdChk("R2", 16'h3d06, 0);
    rdChk("R2", 16'h0000, 0);

    // R3 / R5: mixed packets, errors on middle beats, concurrent reads
    curReq = "R3/R5";
    stopRd = 0;
    fork
      begin
        for (int p = 0; p < 30; p++)
          sendPkt(1 + $urandom % 6, $urandom % 8,
                  ($urandom % 2) ? 6'($urandom) : 6'h00, 6'h3f);
        stopRd = 1;
      end
      reader();
    join
    sendPkt(3, 0, 6'h00, 6'h3f);
    rdChk("R3", 16'h3d01, mGood);
    rdChk("R5", 16'h3d03, mBytes % 256);

    // R4: stray beats with no packet open
    curReq = "R4";
    rd(16'h3d03); savedLo = regRdata;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxValid = 1'b1; rxSop = 1'b0; rxEop = (i % 3 == 0);
      rxErr = 6'h01;
    end
    @(negedge clk); rxValid = 1'b0; rxEop = 1'b0; rxErr = '0;
    rdChk("R4", 16'h3d03, savedLo);

    // R6: bit positions and stickiness
    curReq = "R6";
    wr(16'h3d07);
    sendPkt(2, 0, 6'h01, 6'h00);
    rdChk("R6", 16'h3d07, 32'h18);
    sendPkt(1, 0, 6'h20, 6'h00);
    rdChk("R6", 16'h3d07, 32'h218);

    // R7: clear together with a new error keeps the new error
    curReq = "R7";
    fork
      wr(16'h3d07);
      sendPkt(1, 0, 6'h04, 6'h00);
    join
    rdChk("R7", 16'h3d07, 32'h48);
    rd(16'h3d01); savedGood = regRdata;
    wr(16'h3d01);
    rdChk("R7", 16'h3d01, savedGood);
    wr(16'h3d07);
    rdChk("R7", 16'h3d07, 0);

    // R8: high word is the snapshot taken at the low read
    curReq = "R8";
    savedHi = mBytes / 256;
    rd(16'h3d03);
    sendPkt(40, 0, 6'h00, 6'h00);
    rdChk("R8", 16'h3d04, savedHi);

    // R11: single-beat packets with various empties
    curReq = "R11";
    for (int e = 0; e < 8; e++) sendPkt(1, e, 6'h00, 6'h00);
    rdChk("R11", 16'h3d03, mBytes % 256);
    rdChk("R11", 16'h3d00, mTot);

    // R9: packet counters saturate
    curReq = "R9";
    for (int p = 0; p < 1100; p++) sendPkt(1, 0, 6'h00, 6'h00);
    rdChk("R9", 16'h3d01, CMAX);
    rdChk("R9", 16'h3d00, CMAX);

    // R10: byte counter saturates
    curReq = "R10";
    for (int p = 0; p < 90; p++) sendPkt(100, 0, 6'h00, 6'h00);
    rdChk("R10", 16'h3d03, 32'hff);
    rdChk("R10", 16'h3d04, 32'hff);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nChecks, nFail);
    $finish;
  end
endmodule